// File: doc/BRIEF.md
# Dual-Mode Byte SPI Controller

This block moves one byte at a time over a four-wire serial link, full duplex: while eight bits leave on one data line, eight bits arrive on the other. A static role input picks between two roles. As master, the block makes the serial clock from the system clock with a programmable divider, drives its own active-low select, drives MOSI and samples MISO. As slave, it follows an external serial clock and select, samples MOSI and drives MISO. The data pins change direction with the role.

The host side is a simple strobe interface. A write puts a byte straight into the shift register; there is no separate transmit holding stage. In master role the same write also starts the transfer. A finished receive byte moves into a read buffer, so the next byte can shift in behind it. Three flags report the state: busy, receive-full and overrun.

The master role always uses clock phase 0, with either idle clock level. The slave role accepts every combination of idle level and phase. In both roles the most significant bit is sent first.

Top module: `spi_duplex_ctrl`

## Requirements
- R1: In master role (mode_master_i=1), a write of wr_data_i while idle sends that byte MSB first on mosi_o and gathers eight bits from miso_i, MSB first. The gathered byte appears on rd_data_o with rx_full_o=1 once the transfer ends.
- R2: In master role, sck_o rests at cpol_i whenever busy_o=0. Data is sampled on the leading edge (the first edge away from cpol_i) and changed on the trailing edge, and cpha_i has no effect.
- R3: In master role, each half period of sck_o lasts max(div_i, 6) system clocks. A byte takes 16 clock edges, and busy_o stays 1 from the clock after the starting write until the last edge.
- R4: In slave role (mode_master_i=0), while ss_ni=0, the block samples mosi_i on the leading edge of sck_i when cpha_i=0 and on the trailing edge when cpha_i=1, for both values of cpol_i. It drives the written byte on miso_o, MSB first, and changes bits on the opposite edge.
- R5: In master role, the block drives sck_o, mosi_o and mst_ss_no_o (low during a transfer), and miso_oe_o=0. In slave role, sck_oe_o=0 and mosi_oe_o=0, and miso_oe_o=1 only while ss_ni=0.
- R6: A write while busy_o=1 is ignored: the byte already being sent goes out unchanged and no new transfer starts.
- R7: rx_full_o is set when a byte completes and is cleared only by rd_en_i. While it is set, rd_data_o holds its value.
- R8: If a byte completes while rx_full_o=1 and there is no read in the same cycle, overrun_o is set and the earlier byte is kept. rd_en_i clears overrun_o.
- R9: In slave role, raising ss_ni before the eighth sampling edge abandons the byte. busy_o returns to 0, rx_full_o stays 0, and the next transfer starts from bit 7 again.
- R10: After reset, busy_o=0, rx_full_o=0, overrun_o=0, rd_data_o=0, and sck_o equals cpol_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_master_i | input | 1 | 1 selects master role, 0 selects slave role |
| cpol_i | input | 1 | Serial clock idle level |
| cpha_i | input | 1 | Clock phase (used in slave role only) |
| div_i | input | DIV_W | Master half period in system clocks, raised to 6 if smaller |
| wr_en_i | input | 1 | Host write strobe for the transmit byte |
| wr_data_i | input | DATA_W | Transmit byte |
| rd_en_i | input | 1 | Host read strobe, clears receive-full and overrun |
| rd_data_o | output | DATA_W | Receive buffer |
| busy_o | output | 1 | Transfer in progress |
| rx_full_o | output | 1 | Receive buffer holds an unread byte |
| overrun_o | output | 1 | A byte completed while the buffer was full |
| sck_i | input | 1 | External serial clock (slave role) |
| sck_o | output | 1 | Generated serial clock (master role) |
| sck_oe_o | output | 1 | Output enable for the serial clock |
| ss_ni | input | 1 | Active-low slave select (slave role) |
| mst_ss_no_o | output | 1 | Active-low select driven in master role |
| mosi_i | input | 1 | MOSI pin input (slave role) |
| mosi_o | output | 1 | MOSI pin output (master role) |
| mosi_oe_o | output | 1 | Output enable for MOSI |
| miso_i | input | 1 | MISO pin input (master role) |
| miso_o | output | 1 | MISO pin output (slave role) |
| miso_oe_o | output | 1 | Output enable for MISO |

## Verification
The bench builds the block with its defaults: DATA_W=8, DIV_W=8, a minimum half period of 6 and two synchronizer stages. With these values a byte is short, so half periods of 6 and 10 clocks, a divider value below the floor and a slave clock of 8-cycle half periods all run quickly. Within that budget the bench covers both master idle levels, all four slave clock modes, a write in the middle of a transfer, two unread completions in a row and a select lost after three bits.

// File: rtl/spi_duplex_pkg.sv
package spi_duplex_pkg;
  localparam int unsigned SPI_MIN_HALF = 6;

  typedef enum logic {
    ROLE_SLAVE  = 1'b0,
    ROLE_MASTER = 1'b1
  } spi_role_e;

  typedef struct packed {
    logic sample;
    logic shift;
  } spi_strobe_t;
endpackage

// File: rtl/spi_sck_gen.sv
module spi_sck_gen #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned DIV_W    = 8,
  parameter int unsigned MIN_HALF = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cpol_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             sck_o,
  output logic             active_o,
  output spi_duplex_pkg::spi_strobe_t strobe_o
);
  localparam int unsigned EDGES  = 2 * DATA_W;
  localparam int unsigned EDGE_W = $clog2(EDGES);

  logic [DIV_W-1:0]  half_lim;
  logic [DIV_W-1:0]  cnt_q;
  logic [EDGE_W-1:0] edge_q;
  logic              phase_q;
  logic              active_q;
  logic              tick;

  assign half_lim = (div_i < DIV_W'(MIN_HALF)) ? DIV_W'(MIN_HALF) : div_i;
  assign tick     = active_q && (cnt_q == half_lim - DIV_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      edge_q   <= '0;
      phase_q  <= 1'b0;
      active_q <= 1'b0;
    end else if (!active_q) begin
      cnt_q   <= '0;
      edge_q  <= '0;
      phase_q <= 1'b0;
      if (start_i) active_q <= 1'b1;
    end else if (tick) begin
      cnt_q   <= '0;
      phase_q <= ~phase_q;
      if (edge_q == EDGE_W'(EDGES - 1)) begin
        active_q <= 1'b0;
        edge_q   <= '0;
      end else begin
        edge_q <= edge_q + EDGE_W'(1);
      end
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end

  // even edge index = leading edge (sample), odd = trailing (shift)
  assign strobe_o.sample = tick && !edge_q[0];
  assign strobe_o.shift  = tick &&  edge_q[0];
  assign sck_o           = cpol_i ^ phase_q;
  assign active_o        = active_q;
endmodule

// File: rtl/spi_slave_front.sv
module spi_slave_front #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic ss_ni,
  input  logic mosi_i,
  input  logic cpol_i,
  input  logic cpha_i,
  output logic sel_o,
  output logic mosi_s_o,
  output spi_duplex_pkg::spi_strobe_t strobe_o
);
  logic [SYNC_STAGES-1:0] sck_pipe, ss_pipe, mosi_pipe;
  logic sck_last_q;
  logic sck_s, sel, edge_seen, lead, trail;

  generate
    if (SYNC_STAGES == 1) begin : g_sync_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          sck_pipe  <= '0;
          ss_pipe   <= '1;
          mosi_pipe <= '0;
        end else begin
          sck_pipe  <= sck_i;
          ss_pipe   <= ss_ni;
          mosi_pipe <= mosi_i;
        end
      end
    end else begin : g_sync_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          sck_pipe  <= '0;
          ss_pipe   <= '1;
          mosi_pipe <= '0;
        end else begin
          sck_pipe  <= {sck_pipe[SYNC_STAGES-2:0], sck_i};
          ss_pipe   <= {ss_pipe[SYNC_STAGES-2:0], ss_ni};
          mosi_pipe <= {mosi_pipe[SYNC_STAGES-2:0], mosi_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_last_q <= 1'b0;
    else         sck_last_q <= sck_pipe[SYNC_STAGES-1];
  end

  assign sck_s     = sck_pipe[SYNC_STAGES-1];
  assign sel       = !ss_pipe[SYNC_STAGES-1];
  assign edge_seen = sel && (sck_s != sck_last_q);
  assign lead      = edge_seen && (sck_s != cpol_i);
  assign trail     = edge_seen && (sck_s == cpol_i);

  assign strobe_o.sample = cpha_i ? trail : lead;
  assign strobe_o.shift  = cpha_i ? lead  : trail;
  assign sel_o           = sel;
  assign mosi_s_o        = mosi_pipe[SYNC_STAGES-1];
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  spi_duplex_pkg::spi_strobe_t strobe_i,
  input  logic              abort_i,
  input  logic              ser_i,
  output logic              ser_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_byte_o
);
  localparam int unsigned CNT_W = $clog2(DATA_W);

  logic [DATA_W-1:0] tx_q, rx_q;
  logic [CNT_W-1:0]  bit_q;
  logic              last_bit;

  assign last_bit = (bit_q == CNT_W'(DATA_W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q  <= '0;
      rx_q  <= '0;
      bit_q <= '0;
    end else if (load_i) begin
      tx_q  <= load_data_i;
      bit_q <= '0;
    end else if (abort_i) begin
      bit_q <= '0;
    end else if (strobe_i.sample) begin
      rx_q  <= {rx_q[DATA_W-2:0], ser_i};
      bit_q <= last_bit ? '0 : bit_q + CNT_W'(1);
    end else if (strobe_i.shift && bit_q != '0) begin
      // no shift before the first sample: the MSB is already on the line
      tx_q <= {tx_q[DATA_W-2:0], 1'b0};
    end
  end

  assign done_o    = !load_i && !abort_i && strobe_i.sample && last_bit;
  assign rx_byte_o = {rx_q[DATA_W-2:0], ser_i};
  assign ser_o     = tx_q[DATA_W-1];
  assign busy_o    = (bit_q != '0);
endmodule

// File: rtl/spi_rx_buf.sv
module spi_rx_buf #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o,
  output logic              ovr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      full_o <= 1'b0;
      ovr_o  <= 1'b0;
    end else begin
      if (rd_en_i) begin
        full_o <= 1'b0;
        ovr_o  <= 1'b0;
      end
      if (done_i) begin
        if (full_o && !rd_en_i) begin
          ovr_o <= 1'b1;
        end else begin
          data_o <= byte_i;
          full_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_duplex_ctrl.sv
module spi_duplex_ctrl #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned DIV_W       = 8,
  parameter int unsigned MIN_HALF    = spi_duplex_pkg::SPI_MIN_HALF,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_master_i,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              busy_o,
  output logic              rx_full_o,
  output logic              overrun_o,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              sck_oe_o,
  input  logic              ss_ni,
  output logic              mst_ss_no_o,
  input  logic              mosi_i,
  output logic              mosi_o,
  output logic              mosi_oe_o,
  input  logic              miso_i,
  output logic              miso_o,
  output logic              miso_oe_o
);
  import spi_duplex_pkg::*;

  spi_role_e   role;
  spi_strobe_t mst_strobe, slv_strobe, strobe;
  logic        mst_active, slv_sel, slv_mosi;
  logic        core_busy, core_done, core_ser_o;
  logic        load, abort, ser_in;
  logic [DATA_W-1:0] core_byte;

  assign role   = mode_master_i ? ROLE_MASTER : ROLE_SLAVE;
  assign busy_o = (role == ROLE_MASTER) ? mst_active : core_busy;
  assign load   = wr_en_i && !busy_o;
  assign abort  = (role == ROLE_SLAVE) && !slv_sel;
  assign strobe = (role == ROLE_MASTER) ? mst_strobe : slv_strobe;
  assign ser_in = (role == ROLE_MASTER) ? miso_i : slv_mosi;

  spi_sck_gen #(
    .DATA_W  (DATA_W),
    .DIV_W   (DIV_W),
    .MIN_HALF(MIN_HALF)
  ) u_sck_gen (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (load && role == ROLE_MASTER),
    .cpol_i  (cpol_i),
    .div_i   (div_i),
    .sck_o   (sck_o),
    .active_o(mst_active),
    .strobe_o(mst_strobe)
  );

  spi_slave_front #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_slave_front (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sck_i   (sck_i),
    .ss_ni   (ss_ni),
    .mosi_i  (mosi_i),
    .cpol_i  (cpol_i),
    .cpha_i  (cpha_i),
    .sel_o   (slv_sel),
    .mosi_s_o(slv_mosi),
    .strobe_o(slv_strobe)
  );

  spi_shift_core #(
    .DATA_W(DATA_W)
  ) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_data_i(wr_data_i),
    .strobe_i   (strobe),
    .abort_i    (abort),
    .ser_i      (ser_in),
    .ser_o      (core_ser_o),
    .busy_o     (core_busy),
    .done_o     (core_done),
    .rx_byte_o  (core_byte)
  );

  spi_rx_buf #(
    .DATA_W(DATA_W)
  ) u_rx_buf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .done_i (core_done),
    .byte_i (core_byte),
    .rd_en_i(rd_en_i),
    .data_o (rd_data_o),
    .full_o (rx_full_o),
    .ovr_o  (overrun_o)
  );

  assign sck_oe_o    = (role == ROLE_MASTER);
  assign mosi_oe_o   = (role == ROLE_MASTER);
  assign mst_ss_no_o = !((role == ROLE_MASTER) && mst_active);
  assign mosi_o      = core_ser_o;
  assign miso_o      = core_ser_o;
  assign miso_oe_o   = (role == ROLE_SLAVE) && !ss_ni;
endmodule

// File: rtl/spi_duplex_ctrl_chk.sv
module spi_duplex_ctrl_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mode_master_i,
  input logic              cpol_i,
  input logic              rd_en_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              busy_o,
  input logic              rx_full_o,
  input logic              overrun_o,
  input logic              sck_o
);
  // R2
  sck_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_master_i && !busy_o) |-> (sck_o == cpol_i));

  // R7
  rx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_full_o && !rd_en_i) |=> (rx_full_o && $stable(rd_data_o)));

  // R8
  ovr_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> $past(rx_full_o));

  // R8
  ovr_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |-> rx_full_o);

  // R1
  full_after_xfer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_full_o) |-> $past(busy_o));
endmodule

bind spi_duplex_ctrl spi_duplex_ctrl_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/spi_duplex_ctrl_bench.sv
module spi_duplex_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SLV_HALF   = 8;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       mode_master_i = 1'b1, cpol_i = 1'b0, cpha_i = 1'b0;
  logic [7:0] div_i = 8'd6;
  logic       wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [7:0] wr_data_i = 8'h00;
  logic [7:0] rd_data_o;
  logic       busy_o, rx_full_o, overrun_o;
  logic       sck_i = 1'b0, ss_ni = 1'b1, mosi_i = 1'b0, miso_i = 1'b0;
  logic       sck_o, sck_oe_o, mst_ss_no_o, mosi_o, mosi_oe_o, miso_o, miso_oe_o;

  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  spi_duplex_ctrl u_spi_duplex_ctrl (
    .clk_i, .rst_ni, .mode_master_i, .cpol_i, .cpha_i, .div_i,
    .wr_en_i, .wr_data_i, .rd_en_i, .rd_data_o, .busy_o, .rx_full_o, .overrun_o,
    .sck_i, .sck_o, .sck_oe_o, .ss_ni, .mst_ss_no_o,
    .mosi_i, .mosi_o, .mosi_oe_o, .miso_i, .miso_o, .miso_oe_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host_read();
    @(negedge clk_i) rd_en_i = 1'b1;
    @(negedge clk_i) rd_en_i = 1'b0;
  endtask

  // master role with a behavioural slave on miso_i/mosi_o
  task automatic run_master(input logic [7:0] tx, input logic [7:0] sl, input logic pol,
                            input logic pha, input logic [7:0] div, input int exp_half,
                            input bit mid_wr, input bit do_read, input logic [7:0] exp_rd,
                            input bit exp_ovr, input string tag);
    logic [7:0] cap = 8'h00;
    logic prev;
    bit half_ok = 1'b1;
    bit ss_ok = 1'b1;
    @(negedge clk_i);
    mode_master_i = 1'b1; cpol_i = pol; cpha_i = pha; div_i = div; miso_i = sl[7];
    @(negedge clk_i);
    chk(sck_o == pol, "R2 idle level", sck_o, pol);
    wr_en_i = 1'b1; wr_data_i = tx;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    chk(busy_o == 1'b1, "R3 busy after start", busy_o, 1);
    prev = sck_o;
    for (int e = 0; e < 16; e++) begin
      int cyc = 0;
      while (sck_o == prev && cyc < 400) begin
        @(negedge clk_i);
        cyc++;
        wr_en_i = mid_wr && e == 4 && cyc == 1;
        wr_data_i = 8'h3C;
      end
      wr_en_i = 1'b0;
      prev = sck_o;
      if (cyc != exp_half) half_ok = 1'b0;
      if (mst_ss_no_o != 1'b0 && e < 15) ss_ok = 1'b0;
      if (e % 2 == 0) cap[7 - e/2] = mosi_o;
      else if (e < 15) miso_i = sl[6 - e/2];
    end
    chk(half_ok, {"R3 half period ", tag}, half_ok, 1);
    chk(ss_ok && mosi_oe_o && sck_oe_o && !miso_oe_o, {"R5 master pins ", tag}, ss_ok, 1);
    chk(cap == tx, {"R1 mosi byte ", tag, mid_wr ? " R6" : ""}, cap, tx);
    @(negedge clk_i);
    chk(busy_o == 1'b0 && sck_o == pol, {"R2 back to idle ", tag}, {busy_o, sck_o}, {1'b0, pol});
    chk(rx_full_o == 1'b1 && rd_data_o == exp_rd, {"R1 R7 rx byte ", tag}, rd_data_o, exp_rd);
    chk(overrun_o == exp_ovr, {"R8 overrun ", tag}, overrun_o, exp_ovr);
    if (do_read) begin
      host_read();
      chk(rx_full_o == 1'b0 && overrun_o == 1'b0, {"R7 R8 read clears ", tag},
          {rx_full_o, overrun_o}, 0);
    end
  endtask

  // slave role with the bench acting as master
  task automatic run_slave(input logic [7:0] host_tx, input logic [7:0] mst, input logic pol,
                           input logic pha, input int nbits, input string tag);
    logic [7:0] cap = 8'h00;
    @(negedge clk_i);
    mode_master_i = 1'b0; cpol_i = pol; cpha_i = pha; sck_i = pol; ss_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    wr_en_i = 1'b1; wr_data_i = host_tx;
    @(negedge clk_i) wr_en_i = 1'b0;
    ss_ni = 1'b0;
    if (!pha) mosi_i = mst[7];
    repeat (SLV_HALF) @(negedge clk_i);
    chk(miso_oe_o && !mosi_oe_o && !sck_oe_o, {"R5 slave pins ", tag},
        {miso_oe_o, mosi_oe_o, sck_oe_o}, 3'b100);
    for (int i = 0; i < nbits; i++) begin
      if (pha) mosi_i = mst[7 - i];
      else cap[7 - i] = miso_o;
      sck_i = ~pol;
      repeat (SLV_HALF) @(negedge clk_i);
      if (pha) cap[7 - i] = miso_o;
      sck_i = pol;
      if (!pha && i < 7) mosi_i = mst[6 - i];
      repeat (SLV_HALF) @(negedge clk_i);
    end
    ss_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    chk(miso_oe_o == 1'b0, {"R5 miso released ", tag}, miso_oe_o, 0);
    if (nbits == 8) begin
      chk(cap == host_tx, {"R4 miso byte ", tag}, cap, host_tx);
      chk(rx_full_o && rd_data_o == mst, {"R4 rx byte ", tag}, rd_data_o, mst);
      host_read();
    end else begin
      chk(busy_o == 1'b0 && rx_full_o == 1'b0, {"R9 aborted ", tag}, {busy_o, rx_full_o}, 0);
    end
  endtask

  task automatic t_reset();
    chk(busy_o == 0 && rx_full_o == 0 && overrun_o == 0, "R10 flags", {busy_o, rx_full_o, overrun_o}, 0);
    chk(rd_data_o == 8'h00, "R10 rd_data", rd_data_o, 0);
    chk(sck_o == cpol_i, "R10 sck idle", sck_o, cpol_i);
  endtask

  task automatic t_master_modes();
    run_master(8'hA5, 8'h3C, 1'b0, 1'b0, 8'd6, 6, 1'b0, 1'b1, 8'h3C, 1'b0, "cpol0");
    run_master(8'h81, 8'h7E, 1'b1, 1'b0, 8'd10, 10, 1'b0, 1'b1, 8'h7E, 1'b0, "cpol1");
    // R2 cpha ignored, R3 divider floor
    run_master(8'h5A, 8'hC3, 1'b0, 1'b1, 8'd2, 6, 1'b0, 1'b1, 8'hC3, 1'b0, "floor");
  endtask

  task automatic t_busy_write();
    run_master(8'h96, 8'h0F, 1'b0, 1'b0, 8'd7, 7, 1'b1, 1'b1, 8'h0F, 1'b0, "midwrite");
  endtask

  task automatic t_overrun();
    run_master(8'h11, 8'h22, 1'b1, 1'b0, 8'd6, 6, 1'b0, 1'b0, 8'h22, 1'b0, "first");
    run_master(8'h33, 8'h44, 1'b1, 1'b0, 8'd6, 6, 1'b0, 1'b1, 8'h22, 1'b1, "second");
  endtask

  task automatic t_slave_modes();
    run_slave(8'hC6, 8'h39, 1'b0, 1'b0, 8, "m00");
    run_slave(8'h1E, 8'hE1, 1'b0, 1'b1, 8, "m01");
    run_slave(8'hB4, 8'h4B, 1'b1, 1'b0, 8, "m10");
    run_slave(8'h72, 8'h8D, 1'b1, 1'b1, 8, "m11");
  endtask

  task automatic t_abort();
    run_slave(8'hFF, 8'hAA, 1'b0, 1'b0, 3, "cut");
    run_slave(8'h5C, 8'h93, 1'b0, 1'b0, 8, "after R9");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    t_master_modes();
    t_busy_write();
    t_overrun();
    t_slave_modes();
    t_abort();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done_flag) begin
      done_flag = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule